// File: doc/BRIEF.md
# Serial Synthesizer Configuration Register

This block receives 21-bit configuration words for a frequency synthesizer over a write-only three-wire link made of data, shift clock and latch strobe. All three wires are sampled in the block's own clock domain. Each rising edge of the shift clock pushes one data bit into the word, most significant bit first. A rising edge of the latch strobe acts on the word, but only when at least 21 bits have arrived since the previous strobe. The two bits received last form a control code. That code steers the frame to one of four targets: the reference divider with its three fast-lock flags, the feedback divider (swallow and main counts) with its pull-in start flag, a restore of default settings, or four test-mode bits.

Divider and pull-in settings first go into shadow registers. They move into the active output registers only on a terminal-count pulse from the reference divider, so a divider is never preset part way through a comparison cycle. While standby is asserted, the transfer is held back and all stored settings are kept. Test bits take effect as soon as the strobe arrives. They are only visible while the test-disable input is low, and they are cleared while it is high. A reference value below 3 is still stored, and an error output reports it.

Top module: `synth_cfg_port`

## Requirements
- R1: After reset the active settings are reference 40, swallow 3, main 181 (feedback 5795), and the flags s, i, e and f are all 1. The test bits, the pending flag and the error flag are all 0.
- R2: Each rising edge of ser_clk shifts ser_data into the word, MSB first. A rising edge of ser_latch acts on the word only if at least 21 bits have been shifted since the last latch edge. With fewer bits the word is ignored and upd_pending does not rise.
- R3: Code bits: word bit 0 is the last bit received (C1) and word bit 1 is the one before it (C2). C1,C2 = 0,0 loads the reference value from word bits 16:2, s from bit 17, i from bit 19 and e from bit 20. Bit 18 is ignored.
- R4: C1,C2 = 1,0 loads the swallow count from word bits 6:2, the main count from bits 19:7 and the pull-in start flag f from bit 20.
- R5: C1,C2 = 1,1 loads the defaults of R1 into every divider and flag setting and clears the error flag.
- R6: C1,C2 = 0,1 loads test bits t0..t3 from word bits 5:2 onto test_bits[3:0] right after the latch edge. test_bits reads 0 while test_dis is high. The stored bits are cleared while test_dis is high, and a test frame latched while test_dis is high is discarded.
- R7: A divider or defaults frame raises upd_pending and leaves the active outputs unchanged. The next ref_tc pulse copies the shadow values to the outputs and clears upd_pending. Without pending data the outputs never change.
- R8: While standby is high, ref_tc has no effect. The active outputs and the pending data are kept until a ref_tc pulse arrives after standby falls.
- R9: A reference frame with a value below 3 is stored and applied like any other. ref_err goes high on its latch edge and stays high until a valid reference frame or a defaults frame is latched.
- R10: When more than 21 bits are shifted before a latch edge, the last 21 received form the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| ser_data | input | 1 | Serial data bit |
| ser_clk | input | 1 | Serial shift clock, rising-edge active |
| ser_latch | input | 1 | Latch strobe, rising-edge active |
| test_dis | input | 1 | High disables and clears the test bits |
| standby | input | 1 | High holds the stored settings and blocks updates |
| ref_tc | input | 1 | Reference divider terminal-count pulse |
| ref_div | output | 15 | Active reference divide value |
| swallow_cnt | output | 5 | Active swallow count |
| main_cnt | output | 13 | Active main count |
| fast_reset_en | output | 1 | Flag s |
| cp_double_en | output | 1 | Flag i |
| auto_end_en | output | 1 | Flag e |
| pullin_start | output | 1 | Flag f |
| test_bits | output | 4 | Test bits t3..t0 |
| upd_pending | output | 1 | Shadow values wait for ref_tc |
| ref_err | output | 1 | Last reference frame was below 3 |

## Verification
The hardest state to reach from the ports is a frame that sits in the shadow registers while the active outputs still show the previous settings. It can only be seen in the window between the latch edge and the terminal-count pulse. The stimulus widens that window on purpose. Every table frame is checked once after its latch edge and again after a ref_tc pulse. Standby is also raised across a ref_tc pulse, so the pending data must survive a pulse that was ignored.

// File: rtl/synth_cfg_port.sv
module synth_cfg_port #(
  parameter int REF_W    = 15,
  parameter int SW_W     = 5,
  parameter int MAIN_W   = 13,
  parameter int DEF_REF  = 40,
  parameter int DEF_SW   = 3,
  parameter int DEF_MAIN = 181,
  parameter int MIN_REF  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_data,
  input  logic              ser_clk,
  input  logic              ser_latch,
  input  logic              test_dis,
  input  logic              standby,
  input  logic              ref_tc,
  output logic [REF_W-1:0]  ref_div,
  output logic [SW_W-1:0]   swallow_cnt,
  output logic [MAIN_W-1:0] main_cnt,
  output logic              fast_reset_en,
  output logic              cp_double_en,
  output logic              auto_end_en,
  output logic              pullin_start,
  output logic [3:0]        test_bits,
  output logic              upd_pending,
  output logic              ref_err
);
  localparam int FRAME_W = MAIN_W + SW_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int S_POS   = REF_W + 2;
  localparam int I_POS   = REF_W + 4;
  localparam int E_POS   = REF_W + 5;

  logic               sclk_q, le_q;
  logic [FRAME_W-1:0] sr;
  logic [CNT_W-1:0]   bit_cnt;
  logic [REF_W-1:0]   sh_ref;
  logic [SW_W-1:0]    sh_sw;
  logic [MAIN_W-1:0]  sh_main;
  logic               sh_s, sh_i, sh_e, sh_f;
  logic [3:0]         t_q;

  wire sclk_rise = ser_clk & ~sclk_q;
  wire le_rise   = ser_latch & ~le_q;
  wire frame_ok  = le_rise && (bit_cnt == CNT_W'(FRAME_W));
  wire ld_ref    = frame_ok && (sr[1:0] == 2'b00);
  wire ld_fb     = frame_ok && (sr[1:0] == 2'b01);
  wire ld_test   = frame_ok && (sr[1:0] == 2'b10);
  wire ld_def    = frame_ok && (sr[1:0] == 2'b11);
  wire apply     = upd_pending && ref_tc && !standby;
  wire [REF_W-1:0] new_ref = sr[REF_W+1:2];

  assign test_bits = test_dis ? 4'b0000 : t_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      le_q    <= 1'b0;
      sr      <= '0;
      bit_cnt <= '0;
    end else begin
      sclk_q <= ser_clk;
      le_q   <= ser_latch;
      if (le_rise)
        bit_cnt <= '0;
      else if (sclk_rise && bit_cnt != CNT_W'(FRAME_W))
        bit_cnt <= bit_cnt + 1'b1;
      if (sclk_rise)
        sr <= {sr[FRAME_W-2:0], ser_data};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_ref  <= REF_W'(DEF_REF);
      sh_sw   <= SW_W'(DEF_SW);
      sh_main <= MAIN_W'(DEF_MAIN);
      {sh_s, sh_i, sh_e, sh_f} <= 4'b1111;
      ref_err <= 1'b0;
    end else if (ld_def) begin
      sh_ref  <= REF_W'(DEF_REF);
      sh_sw   <= SW_W'(DEF_SW);
      sh_main <= MAIN_W'(DEF_MAIN);
      {sh_s, sh_i, sh_e, sh_f} <= 4'b1111;
      ref_err <= 1'b0;
    end else if (ld_ref) begin
      sh_ref  <= new_ref;
      sh_s    <= sr[S_POS];
      sh_i    <= sr[I_POS];
      sh_e    <= sr[E_POS];
      ref_err <= (new_ref < REF_W'(MIN_REF));
    end else if (ld_fb) begin
      sh_sw   <= sr[SW_W+1:2];
      sh_main <= sr[FRAME_W-2:SW_W+2];
      sh_f    <= sr[FRAME_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      upd_pending <= 1'b0;
    else if (ld_ref || ld_fb || ld_def)
      upd_pending <= 1'b1;
    else if (apply)
      upd_pending <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_div       <= REF_W'(DEF_REF);
      swallow_cnt   <= SW_W'(DEF_SW);
      main_cnt      <= MAIN_W'(DEF_MAIN);
      fast_reset_en <= 1'b1;
      cp_double_en  <= 1'b1;
      auto_end_en   <= 1'b1;
      pullin_start  <= 1'b1;
    end else if (apply) begin
      ref_div       <= sh_ref;
      swallow_cnt   <= sh_sw;
      main_cnt      <= sh_main;
      fast_reset_en <= sh_s;
      cp_double_en  <= sh_i;
      auto_end_en   <= sh_e;
      pullin_start  <= sh_f;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      t_q <= 4'b0000;
    else if (test_dis)
      t_q <= 4'b0000;
    else if (ld_test)
      t_q <= sr[5:2];
  end
endmodule

// File: rtl/synth_cfg_port_chk.sv
module synth_cfg_port_chk #(
  parameter int REF_W  = 15,
  parameter int MAIN_W = 13,
  parameter int SW_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              standby,
  input logic              ref_tc,
  input logic              test_dis,
  input logic              le_rise,
  input logic              frame_ok,
  input logic [1:0]        code,
  input logic [REF_W-1:0]  new_ref,
  input logic [3:0]        t_q,
  input logic [REF_W-1:0]  ref_div,
  input logic [SW_W-1:0]   swallow_cnt,
  input logic [MAIN_W-1:0] main_cnt,
  input logic              pullin_start,
  input logic              upd_pending,
  input logic              ref_err
);
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_pending |=> $stable(ref_div) && $stable(main_cnt) && $stable(swallow_cnt));

  p_apply_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_pending && ref_tc && !standby && !le_rise) |=> !upd_pending);

  p_standby_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> $stable(ref_div) && $stable(main_cnt) && $stable(pullin_start));

  p_test_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    test_dis |=> (t_q == 4'b0000));

  p_short_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && !frame_ok && !ref_tc) |=> $stable(upd_pending));

  p_low_ref_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && code == 2'b00 && new_ref < REF_W'(3)) |=> ref_err);
endmodule

bind synth_cfg_port synth_cfg_port_chk #(.REF_W(REF_W), .MAIN_W(MAIN_W), .SW_W(SW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .standby(standby), .ref_tc(ref_tc), .test_dis(test_dis),
  .le_rise(le_rise), .frame_ok(frame_ok), .code(sr[1:0]), .new_ref(new_ref), .t_q(t_q),
  .ref_div(ref_div), .swallow_cnt(swallow_cnt), .main_cnt(main_cnt),
  .pullin_start(pullin_start), .upd_pending(upd_pending), .ref_err(ref_err));

// File: tb/synth_cfg_port_test.sv
module synth_cfg_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_data = 1'b0, ser_clk = 1'b0, ser_latch = 1'b0;
  logic test_dis = 1'b1, standby = 1'b0, ref_tc = 1'b0;
  logic [14:0] ref_div;
  logic [4:0]  swallow_cnt;
  logic [12:0] main_cnt;
  logic fast_reset_en, cp_double_en, auto_end_en, pullin_start;
  logic [3:0] test_bits;
  logic upd_pending, ref_err;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  synth_cfg_port uut (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk), .ser_latch(ser_latch),
    .test_dis(test_dis), .standby(standby), .ref_tc(ref_tc), .ref_div(ref_div),
    .swallow_cnt(swallow_cnt), .main_cnt(main_cnt), .fast_reset_en(fast_reset_en),
    .cp_double_en(cp_double_en), .auto_end_en(auto_end_en), .pullin_start(pullin_start),
    .test_bits(test_bits), .upd_pending(upd_pending), .ref_err(ref_err));

  // entry: {frame, ref, swallow, main, {e,i,s,f}, err}
  localparam int NV = 7;
  localparam logic [58:0] VEC [NV] = '{
    {21'h00000C, 15'd3,     5'd3,  13'd181,  4'b0001, 1'b0},
    {21'h0FFFFD, 15'd3,     5'd31, 13'd8191, 4'b0000, 1'b0},
    {21'h13FFFC, 15'd32767, 5'd31, 13'd8191, 4'b1010, 1'b0},
    {21'h100181, 15'd32767, 5'd0,  13'd3,    4'b1011, 1'b0},
    {21'h080008, 15'd2,     5'd0,  13'd3,    4'b0101, 1'b1},
    {21'h180190, 15'd100,   5'd0,  13'd3,    4'b1101, 1'b0},
    {21'h000003, 15'd40,    5'd3,  13'd181,  4'b1111, 1'b0}
  };

  function automatic logic [37:0] snap();
    return {ref_div, swallow_cnt, main_cnt, auto_end_en, cp_double_en, fast_reset_en, pullin_start};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); ser_data = b; ser_clk = 1'b1;
    @(negedge clk); ser_clk = 1'b0;
  endtask

  task automatic send_word(input logic [20:0] w);
    for (int k = 20; k >= 0; k--) send_bit(w[k]);
  endtask

  task automatic latch();
    @(negedge clk); ser_latch = 1'b1;
    @(negedge clk); ser_latch = 1'b0;
  endtask

  task automatic tc_pulse();
    @(negedge clk); ref_tc = 1'b1;
    @(negedge clk); ref_tc = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [37:0] prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset settings", snap(), {15'd40, 5'd3, 13'd181, 4'b1111});
    check("R1 reset test/pending/err", {test_bits, upd_pending, ref_err}, 6'b0);
    test_dis = 1'b0;

    for (int v = 0; v < NV; v++) begin
      prev = snap();
      send_word(VEC[v][58:38]);
      latch();
      check("R7 pending after latch", upd_pending, 1'b1);
      check("R7 outputs held before tc", snap(), prev);
      check("R9 error flag", ref_err, VEC[v][0]);
      tc_pulse();
      check("R3 R4 R5 applied values", snap(), VEC[v][37:1]);
      check("R7 pending cleared", upd_pending, 1'b0);
    end

    // R2: short frame ignored
    prev = snap();
    for (int k = 0; k < 10; k++) send_bit(1'b1);
    latch();
    check("R2 short frame no pending", upd_pending, 1'b0);
    tc_pulse();
    check("R2 short frame outputs", snap(), prev);

    // R10: extra leading bits dropped, last 21 bits used (R=77, flags e,i,s = 0)
    for (int k = 0; k < 4; k++) send_bit(1'b1);
    send_word(21'd308);
    latch();
    tc_pulse();
    check("R10 last 21 bits", snap(), {15'd77, 5'd3, 13'd181, 4'b0001});

    // R6: test bits
    send_word(21'd42);
    latch();
    check("R6 test bits loaded", test_bits, 4'b1010);
    check("R6 test frame not deferred", upd_pending, 1'b0);
    @(negedge clk); test_dis = 1'b1;
    #1;
    check("R6 test bits masked", test_bits, 4'b0000);
    @(negedge clk); test_dis = 1'b0;
    @(negedge clk);
    check("R6 test bits cleared", test_bits, 4'b0000);
    test_dis = 1'b1;
    send_word(21'd62);
    latch();
    @(negedge clk); test_dis = 1'b0;
    @(negedge clk);
    check("R6 frame ignored while disabled", test_bits, 4'b0000);

    // R8: standby holds
    send_word(21'd2000);
    latch();
    @(negedge clk); standby = 1'b1;
    tc_pulse();
    check("R8 standby holds outputs", ref_div, 15'd77);
    check("R8 standby keeps pending", upd_pending, 1'b1);
    @(negedge clk); standby = 1'b0;
    tc_pulse();
    check("R8 applied after standby", ref_div, 15'd500);

    // R9: low reference, then defaults clears error
    send_word(21'd4);
    latch();
    check("R9 err on R=1", ref_err, 1'b1);
    tc_pulse();
    check("R9 low value stored", ref_div, 15'd1);
    send_word(21'd3);
    latch();
    check("R9 R5 defaults clear err", ref_err, 1'b0);
    tc_pulse();
    check("R5 defaults applied", snap(), {15'd40, 5'd3, 13'd181, 4'b1111});

    finish_run();
  end
endmodule